// File: doc/BRIEF.md
# Four-Bit Multi-Function Execution Unit

This block is the arithmetic core of a tiny 4-bit processor. It receives two register operands, `a_i` (the destination register's value) and `b_i` (the source register's value), together with a 3-bit operation code. In the same cycle it returns a result and two flags. The block holds no state: register storage, instruction decoding and sequencing all live outside it. The surrounding datapath writes the result back into the register that supplied `a_i`.

There are seven operations behind the code. Signed addition and signed subtraction share one ripple adder. A small multiplier uses only the low bits of each operand. A shifter moves `a_i` by one place in either direction. A signed comparator picks the larger or the smaller operand. The overflow flag reports when an addition or subtraction leaves the signed range. The zero flag reports when the result is zero.

Top module: `exu_top`

## Requirements
- R1: Code 0 (add) gives result = (a_i + b_i) mod 16, with both operands read as 4-bit two's-complement values.
- R2: Code 1 (subtract) gives result = (a_i - b_i) mod 16, computed as a_i plus the inverted b_i plus one on the same adder as R1.
- R3: ovf_o is 1 exactly when code is 0 or 1 and the true signed sum or difference lies outside -8..7; for every other code ovf_o is 0.
- R4: Code 2 (multiply) gives result = a_i[1:0] * b_i[1:0] as an unsigned value of 0..9; bits 3:2 of both operands have no effect on the result.
- R5: Code 3 (shift left) gives result = {a_i[2:0], 1'b0}; b_i has no effect.
- R6: Code 4 (shift right) gives result = {1'b0, a_i[3:1]}, a logical shift; b_i has no effect.
- R7: Code 5 (max) gives whichever of a_i, b_i is larger as a signed two's-complement value.
- R8: Code 6 (min) gives whichever of a_i, b_i is smaller as a signed two's-complement value.
- R9: zero_o is 1 exactly when the 4-bit result is 0000, for every code.
- R10: Code 7 is reserved and gives result 0000, so zero_o = 1 and ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand; its register receives the result |
| b_i | input | 4 | Second operand |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 mul, 3 shl, 4 shr, 5 max, 6 min, 7 reserved) |
| result_o | output | 4 | Operation result |
| zero_o | output | 1 | High when result_o is zero |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The embedded checks assume that the operands and the code are settled, two-state values. They are evaluated whenever a combinational input changes. The bench therefore drives all three inputs together on the falling clock edge and samples only after they have settled. Every operand pair is run under every code, including reserved code 7, so the checks see all legal input combinations. Seeded random vectors repeat that coverage, and a handful of directed signed-boundary cases add to it.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_SHL = 3'd3,
        OP_SHR = 3'd4,
        OP_MAX = 3'd5,
        OP_MIN = 3'd6,
        OP_RSV = 3'd7
    } exu_op_e;

endpackage

// File: rtl/exu_addsub.sv
module exu_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         neg_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    localparam int SMAX = (2 ** (W - 1)) - 1;
    localparam int SMIN = -(2 ** (W - 1));

    logic [W-1:0] b_x;
    logic [W:0]   carry;

    assign b_x      = b_i ^ {W{neg_i}};
    assign carry[0] = neg_i;

    // one full adder per bit, carries rippling upward
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum_o[i]     = a_i[i] ^ b_x[i] ^ carry[i];
        assign carry[i + 1] = (a_i[i] & b_x[i]) | (carry[i] & (a_i[i] ^ b_x[i]));
    end

    assign ovf_o = carry[W] ^ carry[W-1];

    int sa_d, sb_d, true_d;
    always_comb begin
        sa_d   = int'($signed(a_i));
        sb_d   = int'($signed(b_i));
        true_d = neg_i ? (sa_d - sb_d) : (sa_d + sb_d);
        a_r1_sum_wraps: assert (sum_o == true_d[W-1:0]);  // R1 / R2
        a_r3_ovf_range: assert (ovf_o == ((true_d > SMAX) || (true_d < SMIN)));
    end

endmodule

// File: rtl/exu_mul.sv
module exu_mul #(
    parameter int W  = 4,
    parameter int MB = 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prod_o
);
    localparam int PW = 2 * MB;

    logic [PW-1:0] pp [MB];
    logic [PW-1:0] acc_d;

    // shifted partial product per multiplier bit
    for (genvar j = 0; j < MB; j++) begin : g_pp
        assign pp[j] = PW'({MB{b_i[j]}} & a_i[MB-1:0]) << j;
    end

    always_comb begin
        acc_d = '0;
        for (int j = 0; j < MB; j++) begin
            acc_d = acc_d + pp[j];
        end
    end

    if (PW == W) begin : g_full
        assign prod_o = acc_d;
    end else begin : g_pad
        assign prod_o = {{(W - PW){1'b0}}, acc_d};
    end

    always_comb begin
        a_r4_prod_low_bits: assert (int'(prod_o) ==
            int'(a_i[MB-1:0]) * int'(b_i[MB-1:0]));
    end

endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] shl_o,
    output logic [W-1:0] shr_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign shl_o[i] = 1'b0;
        end else begin : g_lmid
            assign shl_o[i] = a_i[i-1];
        end
        if (i == W - 1) begin : g_msb
            assign shr_o[i] = 1'b0;
        end else begin : g_rmid
            assign shr_o[i] = a_i[i+1];
        end
    end

    always_comb begin
        a_r5_shl_zero_fill: assert (shl_o[0] == 1'b0 && (shl_o >> 1) == (a_i & ~(W'(1) << (W - 1))));
        a_r6_shr_zero_fill: assert (shr_o[W-1] == 1'b0 && (shr_o << 1) == (a_i & ~W'(1)));
    end

endmodule

// File: rtl/exu_cmp.sv
module exu_cmp #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] max_o,
    output logic [W-1:0] min_o
);
    logic a_gt_d;

    assign a_gt_d = $signed(a_i) > $signed(b_i);
    assign max_o  = a_gt_d ? a_i : b_i;
    assign min_o  = a_gt_d ? b_i : a_i;

    always_comb begin
        a_r7_pair_kept: assert ((max_o == a_i && min_o == b_i) ||
                                (max_o == b_i && min_o == a_i));
        a_r8_ordered: assert ($signed(max_o) >= $signed(min_o));
    end

endmodule

// File: rtl/exu_top.sv
module exu_top
    import exu_pkg::*;
#(
    parameter int WIDTH    = 4,
    parameter int MUL_BITS = 2
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [OP_W-1:0]  op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             zero;
        logic             ovf;
    } exu_out_t;

    exu_op_e          op_d;
    logic [WIDTH-1:0] sum_d, prod_d, shl_d, shr_d, max_d, min_d;
    logic             add_ovf_d;
    exu_out_t         out_d;

    assign op_d = exu_op_e'(op_i);

    exu_addsub #(.W(WIDTH)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .neg_i (op_d == OP_SUB),
        .sum_o (sum_d),
        .ovf_o (add_ovf_d)
    );

    exu_mul #(.W(WIDTH), .MB(MUL_BITS)) u_mul (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod_d)
    );

    exu_shift #(.W(WIDTH)) u_shift (
        .a_i   (a_i),
        .shl_o (shl_d),
        .shr_o (shr_d)
    );

    exu_cmp #(.W(WIDTH)) u_cmp (
        .a_i   (a_i),
        .b_i   (b_i),
        .max_o (max_d),
        .min_o (min_d)
    );

    always_comb begin
        out_d = '0;
        case (op_d)
            OP_ADD, OP_SUB: begin
                out_d.result = sum_d;
                out_d.ovf    = add_ovf_d;
            end
            OP_MUL:  out_d.result = prod_d;
            OP_SHL:  out_d.result = shl_d;
            OP_SHR:  out_d.result = shr_d;
            OP_MAX:  out_d.result = max_d;
            OP_MIN:  out_d.result = min_d;
            default: out_d.result = '0;
        endcase
        out_d.zero = (out_d.result == '0);
    end

    assign result_o = out_d.result;
    assign zero_o   = out_d.zero;
    assign ovf_o    = out_d.ovf;

    always_comb begin
        a_r3_no_overflow: assert (!ovf_o || op_d == OP_ADD || op_d == OP_SUB);
        a_r10_reserved: assert (op_d != OP_RSV || (zero_o && !ovf_o));
        a_r7_max_picks_operand: assert (op_d != OP_MAX || result_o == a_i || result_o == b_i);
    end

endmodule

// File: tb/sim_exu_top.sv
module sim_exu_top;
    logic       clk = 1'b0;
    logic [3:0] a, b;
    logic [2:0] op;
    logic [3:0] res;
    logic       zf, of;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    exu_top u0 (
        .a_i      (a),
        .b_i      (b),
        .op_i     (op),
        .result_o (res),
        .zero_o   (zf),
        .ovf_o    (of)
    );

    function automatic int sx(input logic [3:0] v);
        return v[3] ? int'(v) - 16 : int'(v);
    endfunction

    function automatic logic [3:0] exp_res(input logic [3:0] x, input logic [3:0] y,
                                           input logic [2:0] o);
        int t;
        case (o)
            3'd0: t = sx(x) + sx(y);
            3'd1: t = sx(x) - sx(y);
            3'd2: t = int'(x % 4) * int'(y % 4);
            3'd3: t = int'(x) * 2;
            3'd4: t = int'(x) / 2;
            3'd5: t = (sx(x) > sx(y)) ? int'(x) : int'(y);
            3'd6: t = (sx(x) < sx(y)) ? int'(x) : int'(y);
            default: t = 0;
        endcase
        return t[3:0];
    endfunction

    function automatic logic exp_ovf(input logic [3:0] x, input logic [3:0] y,
                                     input logic [2:0] o);
        int t;
        if (o > 3'd1) return 1'b0;
        t = (o == 3'd0) ? sx(x) + sx(y) : sx(x) - sx(y);
        return (t > 7) || (t < -8);
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int expv,
                         input logic [3:0] x, input logic [3:0] y, input logic [2:0] o);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s a=%h b=%h op=%0d actual=%0d expected=%0d", tag, x, y, o, act, expv);
        end
    endtask

    task automatic run(input logic [3:0] x, input logic [3:0] y, input logic [2:0] o);
        logic [3:0] er;
        @(negedge clk);
        a = x; b = y; op = o;
        #5;
        er = exp_res(x, y, o);
        check(tag_of(o), int'(res), int'(er), x, y, o);
        check("R9", int'(zf), int'(er == 4'd0), x, y, o);
        check("R3", int'(of), int'(exp_ovf(x, y, o)), x, y, o);
    endtask

    initial begin
        int seed;
        a = 4'd0; b = 4'd0; op = 3'd0;
        #5;
        // idle state with all inputs zero: add gives zero
        check("R9", int'(zf), 1, a, b, op);
        check("R1", int'(res), 0, a, b, op);
        check("R3", int'(of), 0, a, b, op);
        // directed signed corners
        run(4'd7, 4'd1, 3'd0);   // R1 / R3: 7+1 overflows to -8
        run(4'h8, 4'hF, 3'd0);   // R3: -8 + -1 overflows
        run(4'h8, 4'd1, 3'd1);   // R2 / R3: -8 - 1 overflows
        run(4'd0, 4'h8, 3'd1);   // R2 / R3: 0 - (-8) overflows
        run(4'hF, 4'hF, 3'd2);   // R4: upper bits ignored, 3*3 = 9
        run(4'hC, 4'h3, 3'd2);   // R4: low bits zero gives zero product
        run(4'h9, 4'h5, 3'd3);   // R5: MSB dropped, zero fill
        run(4'h9, 4'hA, 3'd4);   // R6: logical, zero fill
        run(4'h7, 4'h8, 3'd5);   // R7: signed 7 beats -8
        run(4'h7, 4'h8, 3'd6);   // R8: signed -8 is smaller
        run(4'h5, 4'h5, 3'd7);   // R10
        // every pair under every code
        for (int o = 0; o < 8; o++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    run(4'(x), 4'(y), 3'(o));
        // seeded random vectors
        seed = $urandom(32'd1050);
        for (int k = 0; k < 1500; k++) begin
            int r;
            r = $urandom;
            run(r[3:0], r[7:4], r[10:8]);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule